// File: doc/BRIEF.md
# Ethernet MAC statistics counter bank

This block keeps a bank of event counters for an Ethernet MAC. Each receive or transmit event arrives as a one-cycle strobe on its own input bit. Strobe bit i feeds counter i. The wiring convention places receive frames at 0, receive good frames at 1, transmit good frames at 2 and receive FIFO overruns at 3. Transmit collisions sit at 18, receive CRC errors at 19 and transmit late collisions at 31. The frame-size bins interleave, with receive on even and transmit on odd indices from 6 to 17. Receive frames of 1519 bytes and longer are counted at 25, and the errored ones among them at 26. The bank does not classify frames; it only counts strobes.

Software drives the bank through a byte-wide command/status register. A flush command walks the bank one counter per cycle. Each counter is copied into a readout buffer and zeroed in the same cycle, so successive dumps return the events since the previous dump. Software then resets the read index and pulls the buffer through a 32-bit data port. Each word carries its own counter index next to the value, so a reader can detect a stream that was disturbed. A clear command zeroes the live counters. A freeze bit stops counting while commands still run.

Top module: `stat_bank`

## Requirements
- R1: At every clock edge where strobe bit i is high and counting is not frozen, counter i grows by one. Counters are zero after reset.
- R2: A counter that holds 2^CNT_W-1 keeps that value under further strobes and does not wrap.
- R3: `ovf_o` goes to 1 one cycle after any counter reaches 2^CNT_W-1. It returns to 0 one cycle after no counter holds that value.
- R4: Writing the command register with bit 2 set (and bit 0 clear) while idle starts a flush. Status bit 2 then reads 1 for exactly NUM_CNT cycles after the accepting edge. In the k-th of those cycles, counter k is copied into the readout buffer and zeroed. A strobe for counter k in that same cycle leaves the counter at 1, and that event is reported by the next dump.
- R5: Writing with bit 0 set while idle starts a clear. Status bit 0 reads 1 for exactly NUM_CNT cycles while the counters are zeroed one per cycle. The readout buffer is left unchanged.
- R6: Bit 3 is a level that every command write loads and that reads back in status bit 3. While it is 1, strobes are ignored, but flush and clear still run.
- R7: `data_o` holds the counter index in bits 31:24 and the buffered value, zero-extended, in bits 23:0. A one-cycle `data_rd_i` pulse moves to the next index, and the next word is present after that edge.
- R8: Writing with bit 1 set returns the read index to 0 at that edge, taking priority over a read. Bit 1 always reads back 0. The index wraps from NUM_CNT-1 to 0.
- R9: If bits 0 and 2 are written together, only the clear runs. Clear and flush bits written while either sweep is running are ignored.
- R10: After reset the status register reads 0, `ovf_o` is 0 and the data port presents index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_CNT | Per-counter event strobes |
| csr_wr_i | input | 1 | Command register write strobe |
| csr_wdata_i | input | 8 | Command write data: bit0 clear, bit1 index reset, bit2 flush, bit3 freeze |
| csr_rdata_o | output | 8 | Status: bit0 clear busy, bit2 flush busy, bit3 freeze, others 0 |
| data_rd_i | input | 1 | Data port read strobe, advances the read index |
| data_o | output | 32 | Index tag in 31:24, buffered counter value in 23:0 |
| ovf_o | output | 1 | Some counter is at its maximum value |

## Verification
The hardest case to reach is a strobe that lands in the exact cycle the flush sweep visits its counter. It must appear in the next dump and not in the current one. A strobe for the last counter in that same cycle must go into the current dump. The bench fires the command, then raises strobes for counter 0 and for counter NUM_CNT-1 on the very next edge. It then checks both dumps. Saturation is reached by building the bench with narrow counters, so a few hundred strobes are enough to pin a counter at its ceiling and raise the overflow flag.

// File: rtl/stat_bank_pkg.sv
`timescale 1ns/1ps
package stat_bank_pkg;
  // command/status bit positions (software decodes these)
  localparam int CMD_CLEAR  = 0;
  localparam int CMD_RINDEX = 1;
  localparam int CMD_FLUSH  = 2;
  localparam int CMD_FREEZE = 3;

  localparam int CSR_W  = 8;
  localparam int TAG_W  = 8;
  localparam int VAL_W  = 24;
  localparam int WORD_W = TAG_W + VAL_W;

  typedef enum logic [1:0] {
    SWP_IDLE  = 2'd0,
    SWP_CLEAR = 2'd1,
    SWP_FLUSH = 2'd2
  } sweep_e;

  // strobe-to-counter wiring convention
  localparam int EV_RX_ALL       = 0;
  localparam int EV_RX_OK        = 1;
  localparam int EV_TX_OK        = 2;
  localparam int EV_RX_FIFO_OVR  = 3;
  localparam int EV_RX_SHORT     = 4;
  localparam int EV_RX_SHORT_BAD = 5;
  localparam int EV_RX_SZ0       = 6;   // even: receive size bins 6..16
  localparam int EV_TX_SZ0       = 7;   // odd: transmit size bins 7..17
  localparam int EV_TX_COLL      = 18;
  localparam int EV_RX_FCS_BAD   = 19;
  localparam int EV_RX_LONG      = 25;
  localparam int EV_RX_LONG_BAD  = 26;
  localparam int EV_TX_LATE_COLL = 31;
endpackage

// File: rtl/stat_ctl.sv
`timescale 1ns/1ps
module stat_ctl
  import stat_bank_pkg::*;
#(
  parameter int NUM_CNT = 32,
  parameter int IDX_W   = $clog2(NUM_CNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_wr_i,
  input  logic [CSR_W-1:0]  csr_wdata_i,
  output logic [CSR_W-1:0]  csr_rdata_o,
  input  logic              data_rd_i,
  output logic              freeze_o,
  output logic              sweep_en_o,
  output logic              sweep_flush_o,
  output logic [IDX_W-1:0]  sweep_idx_o,
  output logic [IDX_W-1:0]  rd_ptr_next_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CNT - 1);

  sweep_e            st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  ptr_q;
  logic              frz_q;
  logic              unused_hi;

  assign unused_hi = ^csr_wdata_i[CSR_W-1:CMD_FREEZE+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SWP_IDLE;
      idx_q <= '0;
      frz_q <= 1'b0;
    end else begin
      if (csr_wr_i) frz_q <= csr_wdata_i[CMD_FREEZE];
      if (st_q == SWP_IDLE) begin
        idx_q <= '0;
        if (csr_wr_i && csr_wdata_i[CMD_CLEAR])      st_q <= SWP_CLEAR;
        else if (csr_wr_i && csr_wdata_i[CMD_FLUSH]) st_q <= SWP_FLUSH;
      end else begin
        if (idx_q == LAST_IDX) begin
          st_q  <= SWP_IDLE;
          idx_q <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (csr_wr_i && csr_wdata_i[CMD_RINDEX]) rd_ptr_next_o = '0;
    else if (data_rd_i) rd_ptr_next_o = (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
    else rd_ptr_next_o = ptr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else     ptr_q <= rd_ptr_next_o;
  end

  assign freeze_o      = frz_q;
  assign sweep_en_o    = (st_q != SWP_IDLE);
  assign sweep_flush_o = (st_q == SWP_FLUSH);
  assign sweep_idx_o   = idx_q;

  always_comb begin
    csr_rdata_o             = '0;
    csr_rdata_o[CMD_CLEAR]  = (st_q == SWP_CLEAR);
    csr_rdata_o[CMD_FLUSH]  = (st_q == SWP_FLUSH);
    csr_rdata_o[CMD_FREEZE] = frz_q;
  end
endmodule

// File: rtl/stat_counters.sv
`timescale 1ns/1ps
module stat_counters #(
  parameter int NUM_CNT = 32,
  parameter int CNT_W   = 24,
  parameter int IDX_W   = $clog2(NUM_CNT)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CNT-1:0]       evt_i,
  input  logic                     freeze_i,
  input  logic                     sweep_en_i,
  input  logic [IDX_W-1:0]         sweep_idx_i,
  output logic [NUM_CNT*CNT_W-1:0] cnt_flat_o,
  output logic                     ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_CNT-1:0] sat;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    logic             hit;
    logic             zap;

    assign hit = evt_i[i] & ~freeze_i;
    assign zap = sweep_en_i && (sweep_idx_i == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst)                           cnt_q <= '0;
      else if (zap)                      cnt_q <= CNT_W'(hit);
      else if (hit && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
    end

    assign sat[i] = (cnt_q == CNT_MAX);
    assign cnt_flat_o[i*CNT_W +: CNT_W] = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) ovf_o <= 1'b0;
    else     ovf_o <= |sat;
  end
endmodule

// File: rtl/stat_snapshot.sv
`timescale 1ns/1ps
module stat_snapshot #(
  parameter int DEPTH = 32,
  parameter int W     = 24,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/stat_bank.sv
`timescale 1ns/1ps
module stat_bank
  import stat_bank_pkg::*;
#(
  parameter int NUM_CNT = 32,
  parameter int CNT_W   = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CNT-1:0] evt_i,
  input  logic               csr_wr_i,
  input  logic [7:0]         csr_wdata_i,
  output logic [7:0]         csr_rdata_o,
  input  logic               data_rd_i,
  output logic [31:0]        data_o,
  output logic               ovf_o
);
  localparam int IDX_W = $clog2(NUM_CNT);

  logic                     freeze;
  logic                     sweep_en;
  logic                     sweep_flush;
  logic [IDX_W-1:0]         sweep_idx;
  logic [IDX_W-1:0]         ptr_next;
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;
  logic [CNT_W-1:0]         snap_rdata;
  logic [TAG_W-1:0]         tag_q;
  logic [VAL_W-1:0]         val_ext;

  stat_ctl #(.NUM_CNT(NUM_CNT), .IDX_W(IDX_W)) u_ctl (
    .clk           (clk),
    .rst           (rst),
    .csr_wr_i      (csr_wr_i),
    .csr_wdata_i   (csr_wdata_i),
    .csr_rdata_o   (csr_rdata_o),
    .data_rd_i     (data_rd_i),
    .freeze_o      (freeze),
    .sweep_en_o    (sweep_en),
    .sweep_flush_o (sweep_flush),
    .sweep_idx_o   (sweep_idx),
    .rd_ptr_next_o (ptr_next)
  );

  stat_counters #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .evt_i       (evt_i),
    .freeze_i    (freeze),
    .sweep_en_i  (sweep_en),
    .sweep_idx_i (sweep_idx),
    .cnt_flat_o  (cnt_flat),
    .ovf_o       (ovf_o)
  );

  stat_snapshot #(.DEPTH(NUM_CNT), .W(CNT_W), .AW(IDX_W)) u_snap (
    .clk     (clk),
    .rst     (rst),
    .we_i    (sweep_flush),
    .waddr_i (sweep_idx),
    .wdata_i (cnt_flat[sweep_idx*CNT_W +: CNT_W]),
    .raddr_i (ptr_next),
    .rdata_o (snap_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) tag_q <= '0;
    else     tag_q <= TAG_W'(ptr_next);
  end

  always_comb begin
    val_ext = '0;
    val_ext[CNT_W-1:0] = snap_rdata;
  end

  assign data_o = {tag_q, val_ext};
endmodule

// File: rtl/stat_bank_chk.sv
`timescale 1ns/1ps
module stat_bank_chk #(
  parameter int NUM_CNT = 32
) (
  input logic        clk,
  input logic        rst,
  input logic        csr_wr_i,
  input logic [7:0]  csr_wdata_i,
  input logic [7:0]  csr_rdata_o,
  input logic        data_rd_i,
  input logic [31:0] data_o
);
  logic rindex_wr;
  logic idle;
  assign rindex_wr = csr_wr_i && csr_wdata_i[1];
  assign idle      = !csr_rdata_o[0] && !csr_rdata_o[2];

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    data_rd_i && !rindex_wr |=> data_o[31:24] ==
      (($past(data_o[31:24]) == 8'(NUM_CNT-1)) ? 8'd0 : $past(data_o[31:24]) + 8'd1)); // R7
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !data_rd_i && !rindex_wr |=> $stable(data_o[31:24])); // R7
  AST_IDX_RESET: assert property (@(posedge clk) disable iff (rst)
    rindex_wr |=> data_o[31:24] == 8'd0); // R8
  AST_RINDEX_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !csr_rdata_o[1]); // R8
  AST_ONE_SWEEP: assert property (@(posedge clk) disable iff (rst)
    !(csr_rdata_o[0] && csr_rdata_o[2])); // R9
  AST_FLUSH_START: assert property (@(posedge clk) disable iff (rst)
    csr_wr_i && csr_wdata_i[2] && !csr_wdata_i[0] && idle |=> csr_rdata_o[2]); // R4
  AST_CLEAR_START: assert property (@(posedge clk) disable iff (rst)
    csr_wr_i && csr_wdata_i[0] && idle |=> csr_rdata_o[0]); // R5
  AST_FREEZE_LOAD: assert property (@(posedge clk) disable iff (rst)
    csr_wr_i |=> csr_rdata_o[3] == $past(csr_wdata_i[3])); // R6
  AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (rst)
    csr_rdata_o[0] && csr_wr_i && csr_wdata_i[2] |=> !csr_rdata_o[2]); // R9
endmodule

bind stat_bank stat_bank_chk #(.NUM_CNT(NUM_CNT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .csr_wr_i    (csr_wr_i),
  .csr_wdata_i (csr_wdata_i),
  .csr_rdata_o (csr_rdata_o),
  .data_rd_i   (data_rd_i),
  .data_o      (data_o)
);

// File: tb/tb_stat_bank.sv
`timescale 1ns/1ps
module tb_stat_bank;
  localparam int CLK_P = 10;
  localparam int N     = 32;
  localparam int CW    = 8;
  localparam int CMAX  = 255;
  localparam int NV    = 6;

  localparam logic [31:0] V_MASK  [NV] = '{32'h0000_0001, 32'h8000_0000, 32'h0000_AAAA,
                                          32'hFFFF_FFFF, 32'h0006_0000, 32'h0000_0000};
  localparam int          V_REP   [NV] = '{5, 12, 3, 9, 20, 4};
  localparam int          V_PROBE [NV] = '{0, 31, 7, 18, 19, 2};
  localparam int          V_EXP   [NV] = '{5, 12, 3, 9, 0, 0};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] evt = '0;
  logic        csr_wr = 1'b0;
  logic [7:0]  csr_wdata = '0;
  logic [7:0]  csr_rdata;
  logic        data_rd = 1'b0;
  logic [31:0] data_o;
  logic        ovf;

  int n_chk = 0;
  int n_bad = 0;
  int live [N];
  int snap [N];
  logic [31:0] words [N];
  logic [7:0]  frz = 8'h00;

  always #(CLK_P/2) clk = ~clk;

  stat_bank #(.NUM_CNT(N), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .evt_i(evt), .csr_wr_i(csr_wr), .csr_wdata_i(csr_wdata),
    .csr_rdata_o(csr_rdata), .data_rd_i(data_rd), .data_o(data_o), .ovf_o(ovf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [7:0] v);
    csr_wr = 1'b1; csr_wdata = v;
    @(negedge clk);
    csr_wr = 1'b0; csr_wdata = '0;
  endtask

  task automatic pulse(input logic [31:0] m, input int n);
    evt = m;
    repeat (n) @(negedge clk);
    evt = '0;
    if (frz[3] == 1'b0)
      for (int i = 0; i < N; i++)
        if (m[i]) live[i] = (live[i] + n > CMAX) ? CMAX : live[i] + n;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (csr_rdata[0] || csr_rdata[2]) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic read_word(output logic [31:0] w);
    w = data_o;
    data_rd = 1'b1;
    @(negedge clk);
    data_rd = 1'b0;
  endtask

  task automatic read_all(input string req);
    logic [31:0] w;
    csr_write(8'h02 | frz);
    for (int i = 0; i < N; i++) begin
      read_word(w);
      words[i] = w;
      chk(w[31:24] == 8'(i), "R7 index tag", int'(w[31:24]), i);
      chk(int'(w[23:0]) == snap[i], req, int'(w[23:0]), snap[i]);
    end
  endtask

  task automatic dump(input string req);
    int n;
    csr_write(8'h04 | frz);
    wait_idle(n);
    for (int i = 0; i < N; i++) begin snap[i] = live[i]; live[i] = 0; end
    read_all(req);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    logic [31:0] w;
    for (int i = 0; i < N; i++) begin live[i] = 0; snap[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state
    chk(csr_rdata == 8'h00, "R10 status after reset", int'(csr_rdata), 0);
    chk(ovf == 1'b0, "R10 ovf after reset", int'(ovf), 0);
    chk(data_o[31:24] == 8'd0, "R10 index after reset", int'(data_o[31:24]), 0);

    // R4 flush busy length, R10 counters zero after reset
    csr_write(8'h04);
    chk(csr_rdata[2] == 1'b1, "R4 flush busy bit", int'(csr_rdata[2]), 1);
    wait_idle(n);
    chk(n == N, "R4 flush busy cycles", n, N);
    read_all("R10 counters zero after reset");

    // R1 table of strobe patterns, each followed by a dump
    for (int e = 0; e < NV; e++) begin
      pulse(V_MASK[e], V_REP[e]);
      dump("R1 counted value");
      chk(int'(words[V_PROBE[e]][23:0]) == V_EXP[e], "R1 table probe",
          int'(words[V_PROBE[e]][23:0]), V_EXP[e]);
    end

    // R4 strobe in the sweep cycle of counter 0 and of counter 31
    pulse(32'h0000_0001, 3);
    pulse(32'h8000_0000, 2);
    csr_write(8'h04);
    evt = 32'h8000_0001;
    @(negedge clk);
    evt = '0;
    wait_idle(n);
    snap[0] = 3; snap[31] = 3;
    for (int i = 1; i < N-1; i++) snap[i] = 0;
    for (int i = 0; i < N; i++) live[i] = 0;
    live[0] = 1;
    read_all("R4 dump with strobe during sweep");
    dump("R4 strobe carried into next period");

    // R6 freeze: strobes ignored, flush still runs
    frz = 8'h08;
    csr_write(frz);
    chk(csr_rdata[3] == 1'b1, "R6 freeze readback", int'(csr_rdata[3]), 1);
    pulse(32'hFFFF_FFFF, 4);
    dump("R6 frozen counts stay zero");
    frz = 8'h00;
    csr_write(frz);
    chk(csr_rdata[3] == 1'b0, "R6 unfreeze readback", int'(csr_rdata[3]), 0);

    // R5 clear: counters zeroed, busy length, buffer untouched
    pulse(32'h0000_0010, 7);
    dump("R1 pre-clear dump");
    pulse(32'h0000_000F, 6);
    csr_write(8'h01);
    chk(csr_rdata[0] == 1'b1, "R5 clear busy bit", int'(csr_rdata[0]), 1);
    wait_idle(n);
    chk(n == N, "R5 clear busy cycles", n, N);
    for (int i = 0; i < N; i++) live[i] = 0;
    read_all("R5 buffer kept across clear");

    // R9 clear and flush together, flush during busy ignored
    pulse(32'h0000_0010, 2);
    csr_write(8'h05);
    chk(csr_rdata[0] == 1'b1 && csr_rdata[2] == 1'b0, "R9 clear wins",
        int'(csr_rdata[2:0]), 1);
    csr_write(8'h04);
    chk(csr_rdata[2] == 1'b0, "R9 flush ignored while busy", int'(csr_rdata[2]), 0);
    wait_idle(n);
    for (int i = 0; i < N; i++) live[i] = 0;
    read_all("R9 buffer not refilled");
    dump("R9 counters cleared");

    // R8 wrap and mid-stream index reset
    pulse(32'h0000_0021, 2);
    dump("R1 wrap setup");
    read_word(w);
    chk(w[31:24] == 8'd0 && int'(w[23:0]) == snap[0], "R8 wrap to index 0",
        int'(w[31:24]), 0);
    read_word(w);
    read_word(w);
    csr_wr = 1'b1; csr_wdata = 8'h02; data_rd = 1'b1;
    @(negedge clk);
    csr_wr = 1'b0; csr_wdata = '0; data_rd = 1'b0;
    chk(data_o[31:24] == 8'd0, "R8 index reset beats read", int'(data_o[31:24]), 0);
    chk(int'(data_o[23:0]) == snap[0], "R8 word after index reset",
        int'(data_o[23:0]), snap[0]);

    // R2 saturation and R3 overflow flag
    chk(ovf == 1'b0, "R3 no overflow yet", int'(ovf), 0);
    pulse(32'h0000_0080, 254);
    chk(ovf == 1'b0, "R3 one below max", int'(ovf), 0);
    pulse(32'h0000_0080, 1);
    chk(ovf == 1'b0, "R3 flag lags one cycle", int'(ovf), 0);
    @(negedge clk);
    chk(ovf == 1'b1, "R3 overflow raised", int'(ovf), 1);
    pulse(32'h0000_0080, 45);
    chk(ovf == 1'b1, "R3 overflow held", int'(ovf), 1);
    dump("R2 saturated value");
    chk(int'(words[7][23:0]) == CMAX, "R2 saturation", int'(words[7][23:0]), CMAX);
    chk(ovf == 1'b0, "R3 overflow drops after flush", int'(ovf), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule